// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block turns eight external interrupt pins into eight active-high level requests for a parent interrupt controller. Each pin is first brought into the clock domain by a two-flop synchroniser. A 2-bit mode then decides what counts as an event on that pin: a low level, a falling edge, a rising edge, or either edge. Every pin has a status flag that records the event. A per-pin mask bit decides whether that flag reaches the pin's request output.

Software uses a plain 32-bit register port with a byte address, a write strobe and a combinational read. Three registers are visible: the status flags, the mode fields and the mask bits. For edge modes, the handler clears a status flag by writing 0 to its bit. For the low-level mode the flag simply follows the pin, and software cannot clear it.

Top module: `pin_sense_unit`

## Requirements
- R1: After reset, the status, mode and mask registers read 0, and every request output is low while the pins are held high.
- R2: The mode register at byte address 0x14 holds a 2-bit field for pin n at bits [2n+1:2n], with codes 0 = low level, 1 = falling edge, 2 = rising edge and 3 = both edges. A read returns the last value written, with the upper 16 bits reading 0.
- R3: In mode 1 a 1-to-0 transition on the pin sets its status bit, and a 0-to-1 transition does not.
- R4: In mode 2 a 0-to-1 transition on the pin sets its status bit, and a 1-to-0 transition does not.
- R5: In mode 3 a transition in either direction sets the status bit.
- R6: In mode 0 the status bit is 1 while the pin is low and 0 while it is high. It follows the pin three clocks after the pin changes, and a write of 0 to it has no effect.
- R7: The status register is at byte address 0x10, with bit n for pin n. In an edge mode (codes 1 to 3), writing 0 to bit n clears it. Writing 1 to any bit never sets it.
- R8: The mask register is at byte address 0x10010, with bit n for pin n. Request output n is high exactly when status bit n is 1 and mask bit n is 0. Masking does not alter the status bit.
- R9: When an edge is detected in the same clock as a software clear of that bit, the status bit ends up set.
- R10: A write that changes a pin's mode field clears that pin's status bit and discards any edge seen in that clock. A pin whose field is unchanged by the write is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | External interrupt pins, asynchronous |
| wrEn | input | 1 | Register write strobe, applied at the clock edge |
| addr | input | 17 | Register byte address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data for `addr`, combinational |
| irqOut | output | 8 | Active-high level request per pin toward the parent |

## Verification
The bench walks all four modes on one pin, using both transition directions. A design with the mode decode swapped would set status on the wrong edge, or miss the second edge in both-edge mode. Directed tests go after four corner cases:
- A clear issued in the same clock as an edge must leave the bit set. A design that gave the clear priority would lose that interrupt.
- A clear aimed at a pin in low-level mode must be refused. A design that allowed it would drop a pending level request.
- Moving a pin from low level to falling edge while the pin is low must drop the old flag. A design without this would report a spurious edge.
- Masking must hold the output low while the flag stays readable. A design that gated the status register itself would lose the pending event.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
  localparam int NUM_PINS = 8;
  localparam int MODE_W   = 2;
  localparam int SENSE_W  = NUM_PINS * MODE_W;
  localparam int ADDR_W   = 17;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 17'h00010;
  localparam logic [ADDR_W-1:0] SENSE_ADDR  = 17'h00014;
  localparam logic [ADDR_W-1:0] MASK_ADDR   = 17'h10010;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // Strobes from the register control to the pin datapath
  typedef struct packed {
    logic [NUM_PINS-1:0] clrReq;   // software clear accepted (edge mode, bit written 0)
    logic [NUM_PINS-1:0] modeChg;  // mode field rewritten with a new value
  } strobe_t;
endpackage

// File: rtl/pin_sense_ctrl.sv
module pin_sense_ctrl
  import pin_sense_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_PINS-1:0] statusQ,
  output logic [SENSE_W-1:0]  senseQ,
  output logic [NUM_PINS-1:0] maskQ,
  output strobe_t             strobe,
  output logic [DATA_W-1:0]   rdData
);
  logic hitStatus, hitSense, hitMask;

  assign hitStatus = (addr == STATUS_ADDR);
  assign hitSense  = (addr == SENSE_ADDR);
  assign hitMask   = (addr == MASK_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseQ <= '0;
      maskQ  <= '0;
    end else begin
      if (wrEn && hitSense) senseQ <= wrData[SENSE_W-1:0];
      if (wrEn && hitMask)  maskQ  <= wrData[NUM_PINS-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_strobe
    logic [MODE_W-1:0] curMode;
    logic [MODE_W-1:0] newMode;
    assign curMode = senseQ[p*MODE_W +: MODE_W];
    assign newMode = wrData[p*MODE_W +: MODE_W];
    assign strobe.clrReq[p]  = wrEn && hitStatus && !wrData[p] &&
                               (sense_e'(curMode) != SENSE_LOW);
    assign strobe.modeChg[p] = wrEn && hitSense && (newMode != curMode);
  end

  always_comb begin
    rdData = '0;
    if (hitStatus)     rdData[NUM_PINS-1:0] = statusQ;
    else if (hitSense) rdData[SENSE_W-1:0]  = senseQ;
    else if (hitMask)  rdData[NUM_PINS-1:0] = maskQ;
  end
endmodule

// File: rtl/pin_sense_dp.sv
module pin_sense_dp
  import pin_sense_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [SENSE_W-1:0]  senseQ,
  input  strobe_t             strobe,
  output logic [NUM_PINS-1:0] statusQ
);
  logic [NUM_PINS-1:0] syncA, syncB, prevB;

  // Pins idle high, so the synchroniser and history reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
      prevB <= '1;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sense_e mode;
    logic   rise, fall, hit;

    assign mode = sense_e'(senseQ[p*MODE_W +: MODE_W]);
    assign rise = syncB[p] & ~prevB[p];
    assign fall = ~syncB[p] & prevB[p];

    always_comb begin
      unique case (mode)
        SENSE_FALL: hit = fall;
        SENSE_RISE: hit = rise;
        SENSE_BOTH: hit = rise | fall;
        default:    hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    statusQ[p] <= 1'b0;
      else if (strobe.modeChg[p])   statusQ[p] <= 1'b0;
      else if (mode == SENSE_LOW)   statusQ[p] <= ~syncB[p];
      else if (hit)                 statusQ[p] <= 1'b1;
      else if (strobe.clrReq[p])    statusQ[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_sense_unit.sv
module pin_sense_unit
  import pin_sense_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_PINS-1:0] irqOut
);
  logic [NUM_PINS-1:0] statusQ;
  logic [NUM_PINS-1:0] maskQ;
  logic [SENSE_W-1:0]  senseQ;
  strobe_t             strobe;

  pin_sense_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .statusQ(statusQ),
    .senseQ (senseQ),
    .maskQ  (maskQ),
    .strobe (strobe),
    .rdData (rdData)
  );

  pin_sense_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .senseQ (senseQ),
    .strobe (strobe),
    .statusQ(statusQ)
  );

  assign irqOut = statusQ & ~maskQ;
endmodule

// File: rtl/pin_sense_chk.sv
module pin_sense_chk
  import pin_sense_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wrData,
  input logic [DATA_W-1:0]   rdData,
  input logic [NUM_PINS-1:0] irqOut,
  input logic [NUM_PINS-1:0] statusQ,
  input logic [NUM_PINS-1:0] maskQ,
  input logic [SENSE_W-1:0]  senseQ
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (statusQ == '0) && (maskQ == '0) && (senseQ == '0));

  // R2
  sense_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SENSE_ADDR) |=> (senseQ == $past(wrData[SENSE_W-1:0])));

  // R2
  sense_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == SENSE_ADDR) |-> (rdData == {{(DATA_W-SENSE_W){1'b0}}, senseQ}));

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == MASK_ADDR) |=> (maskQ == $past(wrData[NUM_PINS-1:0])));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == MASK_ADDR && (&wrData[NUM_PINS-1:0])) |=> (irqOut == '0));
endmodule

bind pin_sense_unit pin_sense_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .irqOut (irqOut),
  .statusQ(statusQ),
  .maskQ  (maskQ),
  .senseQ (senseQ)
);

// File: tb/tb_pin_sense_unit.sv
`timescale 1ns/1ps
module tb_pin_sense_unit;
  import pin_sense_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [NUM_PINS-1:0] pinIn = '1;
  logic                wrEn = 1'b0;
  logic [ADDR_W-1:0]   addr = '0;
  logic [DATA_W-1:0]   wrData = '0;
  logic [DATA_W-1:0]   rdData;
  logic [NUM_PINS-1:0] irqOut;

  int checks = 0;
  int errors = 0;

  pin_sense_unit dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  // Vector: {mode[1:0], startLevel, endLevel, expectedStatus}
  localparam logic [4:0] VEC [8] = '{
    5'b01_10_1, // falling, 1->0 sets
    5'b01_01_0, // falling, 0->1 ignored
    5'b10_01_1, // rising, 0->1 sets
    5'b10_10_0, // rising, 1->0 ignored
    5'b11_10_1, // both, 1->0 sets
    5'b11_01_1, // both, 0->1 sets
    5'b00_10_1, // low level, pin ends low
    5'b00_01_0  // low level, pin ends high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd1:    return "R3 falling";
      2'd2:    return "R4 rising";
      2'd3:    return "R5 both";
      default: return "R6 level";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(4);

    // R1 reset state
    busRead(STATUS_ADDR, rd); check("R1 status", rd, 32'h0);
    busRead(SENSE_ADDR, rd);  check("R1 sense", rd, 32'h0);
    busRead(MASK_ADDR, rd);   check("R1 mask", rd, 32'h0);
    check("R1 irqOut", {24'h0, irqOut}, 32'h0);

    // Table walk on pin 0
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      logic       st, en, ex;
      {m, st, en, ex} = VEC[i];
      pinIn[0] = st;
      waitCycles(5);
      busWrite(SENSE_ADDR, {30'h0, m});
      waitCycles(2);
      busWrite(STATUS_ADDR, 32'h0);
      waitCycles(1);
      pinIn[0] = en;
      waitCycles(5);
      busRead(STATUS_ADDR, rd);
      check($sformatf("%s status vec %0d", modeTag(m), i), {31'h0, rd[0]}, {31'h0, ex});
      check($sformatf("%s R8 irqOut vec %0d", modeTag(m), i), {31'h0, irqOut[0]}, {31'h0, ex});
    end

    // R2 sense readback
    busWrite(SENSE_ADDR, 32'hFFFF_C01B);
    waitCycles(1);
    busRead(SENSE_ADDR, rd); check("R2 sense readback", rd, 32'h0000_C01B);

    // R6 level mode clear refused
    busWrite(SENSE_ADDR, 32'h0);
    pinIn[0] = 1'b0;
    waitCycles(5);
    busWrite(STATUS_ADDR, 32'h0);
    waitCycles(1);
    busRead(STATUS_ADDR, rd); check("R6 level clear ignored", {31'h0, rd[0]}, 32'h1);
    pinIn[0] = 1'b1;
    waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R6 level follows high", {31'h0, rd[0]}, 32'h0);

    // R7 write 1 does not set, write 0 clears in edge mode
    busWrite(SENSE_ADDR, 32'h2);
    busWrite(STATUS_ADDR, 32'hFF);
    waitCycles(1);
    busRead(STATUS_ADDR, rd); check("R7 write one no set", rd, 32'h0);
    pinIn[0] = 1'b0; waitCycles(5);
    pinIn[0] = 1'b1; waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R4 rising set", {31'h0, rd[0]}, 32'h1);

    // R8 mask blocks output but keeps status
    busWrite(MASK_ADDR, 32'h1);
    waitCycles(1);
    check("R8 masked irqOut", {31'h0, irqOut[0]}, 32'h0);
    busRead(STATUS_ADDR, rd); check("R8 status kept", {31'h0, rd[0]}, 32'h1);
    busWrite(MASK_ADDR, 32'h0);
    waitCycles(1);
    check("R8 unmasked irqOut", {31'h0, irqOut[0]}, 32'h1);
    busWrite(STATUS_ADDR, 32'h0);
    waitCycles(1);
    busRead(STATUS_ADDR, rd); check("R7 edge clear", {31'h0, rd[0]}, 32'h0);

    // R9 edge in same clock as clear
    busWrite(SENSE_ADDR, 32'hA);
    pinIn[1] = 1'b0;
    waitCycles(5);
    busWrite(STATUS_ADDR, 32'h0);
    waitCycles(1);
    busRead(STATUS_ADDR, rd); check("R9 precleared", {31'h0, rd[1]}, 32'h0);
    pinIn[1] = 1'b1;
    waitCycles(2);
    wrEn = 1'b1; addr = STATUS_ADDR; wrData = 32'h0;
    @(negedge clk);
    wrEn = 1'b0;
    waitCycles(1);
    busRead(STATUS_ADDR, rd); check("R9 edge wins", {31'h0, rd[1]}, 32'h1);

    // R10 mode change re-primes pin 2
    pinIn[2] = 1'b0;
    waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R6 pin2 low level", {31'h0, rd[2]}, 32'h1);
    busWrite(SENSE_ADDR, 32'h1A);
    waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R10 mode change clears", {31'h0, rd[2]}, 32'h0);
    check("R10 other pin untouched", {31'h0, rd[1]}, 32'h1);
    pinIn[2] = 1'b1; waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R3 pin2 rise ignored", {31'h0, rd[2]}, 32'h0);
    pinIn[2] = 1'b0; waitCycles(5);
    busRead(STATUS_ADDR, rd); check("R3 pin2 fall sets", {31'h0, rd[2]}, 32'h1);

    // R5 both edges on pin 7, field at bits 15:14
    busWrite(SENSE_ADDR, 32'hC01A);
    busWrite(STATUS_ADDR, 32'h0);
    pinIn[7] = 1'b0; waitCycles(5);
    check("R5 pin7 fall irqOut", {31'h0, irqOut[7]}, 32'h1);
    busWrite(STATUS_ADDR, 32'h0);
    waitCycles(1);
    check("R7 pin7 cleared", {31'h0, irqOut[7]}, 32'h0);
    pinIn[7] = 1'b1; waitCycles(5);
    check("R5 pin7 rise irqOut", {31'h0, irqOut[7]}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule